// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM that has two chip selects (one active low, one active high), an active-low output enable, an active-low write enable and a shared bidirectional data bus. The host issues one single-word read or write at a time. The block turns each request into a sequence of registered strobe phases, and each phase is long enough to meet the RAM's nanosecond timing minimums at the configured clock period.

Every phase length comes from a timing parameter in picoseconds divided by the clock period. The result is rounded up, and each phase is at least one cycle long. Writes are controlled by the write-enable strobe, with output enable held high the whole time, so the RAM never drives the bus while the block does. After a read, the block waits a turnaround gap before the bus may be driven again. Requests are refused for a power-up hold-off interval after reset. Between accesses the RAM is deselected so that it stays in standby.

The data bus is split into three signals for the pad ring: an output value, an output enable and an input value.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0 and host_ready=0.
- R2: After reset is released, host_busy stays high for exactly ceil(T_PWR_PS/CLK_PS) cycles (20000 at defaults). A request made in that window is dropped: no chip select is asserted, no ready pulse occurs, and the RAM is not modified.
- R3: A write holds mem_ce1_n=0, mem_ce2=1, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1 for WL = max(cyc(7 ns), cyc(6 ns), cyc(7 ns)) cycles (2 at defaults). Address and write data stay constant over that span. The bus is released on the same edge that raises mem_we_n, and the location is updated with the driven data.
- R4: After WE rises, a write keeps the chip selected with WE high for max(1, cyc(10 ns) - WL) cycles. host_ready is then high in the cycle that follows, 1 + WL + that count cycles after the request cycle (4 at defaults).
- R5: A read holds chips selected, mem_oe_n=0 and mem_we_n=1 for RL = max(cyc(10 ns), cyc(5 ns)) cycles (2 at defaults). mem_dq_in is captured at the end of the last of those cycles and appears on host_rdata together with host_ready, 1 + RL cycles after the request cycle.
- R6: host_ready is high for exactly one cycle per accepted access, and host_rdata keeps its value after the pulse.
- R7: While host_busy is high, host_req is ignored: no second access runs, and the address and data presented in that time are not written.
- R8: mem_dq_oe is never high while mem_oe_n is low, and mem_oe_n never falls in the cycle right after mem_dq_oe was high. After a read drops mem_oe_n, at least cyc(5 ns) cycles pass before mem_dq_oe rises.
- R9: Whenever host_busy is low, the RAM is deselected (mem_ce1_n=1, mem_ce2=0) with mem_oe_n=1 and mem_we_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, sampled when not busy |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 8 | Write data |
| host_busy | output | 1 | High during hold-off or while an access runs |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last read result |
| mem_addr | output | 17 | RAM address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
The bench models the RAM at its pins. A write is committed only when the write-enable strobe ends, and when the RAM is not driving the bus the model returns a poison value. With this model, a controller that captures too early, releases the bus late or runs a shortened write returns wrong read data or trips the contention monitor. Requests are aimed at the power-up hold-off window and at the cycles just after a request is accepted, so a controller that queued or accepted such requests would corrupt a location that is later read back. Exact latency counts catch phase lengths that round down or skip the one-cycle minimum. A tracker of the gap between a read's OE release and the next bus drive catches a missing turnaround.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LOW,
        ST_WR_REC,
        ST_RD_OE,
        ST_RD_TURN
    } seq_state_e;

    // picoseconds to whole cycles, rounded up, never below one
    function automatic int unsigned ps_to_cyc(int unsigned ps, int unsigned clk_ps);
        int unsigned c;
        c = (ps + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_powerup_gate.sv
module sram_powerup_gate #(
    parameter int unsigned HOLD_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    output logic ok
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!g_q.ok) begin
            g_d.cnt = g_q.cnt + 1'b1;
            g_d.ok  = (g_q.cnt == CW'(HOLD_CYC - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) g_q <= '0;
        else     g_q <= g_d;
    end

    assign ok = g_q.ok;
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q <= CW'(1));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 5000,
    parameter int unsigned T_PWR_PS  = 100_000_000,
    parameter int unsigned T_WC_PS   = 10000,
    parameter int unsigned T_PWE_PS  = 7000,
    parameter int unsigned T_AW_PS   = 7000,
    parameter int unsigned T_SD_PS   = 6000,
    parameter int unsigned T_RC_PS   = 10000,
    parameter int unsigned T_AA_PS   = 10000,
    parameter int unsigned T_ACE_PS  = 10000,
    parameter int unsigned T_DOE_PS  = 5000,
    parameter int unsigned T_HZ_PS   = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned WR_LOW_CYC = umax(umax(ps_to_cyc(T_PWE_PS, CLK_PS),
                                                   ps_to_cyc(T_AW_PS, CLK_PS)),
                                              ps_to_cyc(T_SD_PS, CLK_PS));
    localparam int unsigned WC_CYC     = ps_to_cyc(T_WC_PS, CLK_PS);
    localparam int unsigned WR_REC_CYC = (WC_CYC > WR_LOW_CYC) ? (WC_CYC - WR_LOW_CYC) : 1;
    localparam int unsigned RD_CYC     = umax(umax(ps_to_cyc(T_RC_PS, CLK_PS),
                                                   ps_to_cyc(T_AA_PS, CLK_PS)),
                                              umax(ps_to_cyc(T_ACE_PS, CLK_PS),
                                                   ps_to_cyc(T_DOE_PS, CLK_PS)));
    localparam int unsigned TURN_CYC   = ps_to_cyc(T_HZ_PS, CLK_PS);
    localparam int unsigned PWR_CYC    = ps_to_cyc(T_PWR_PS, CLK_PS);
    localparam int unsigned T_MAX      = umax(umax(WR_LOW_CYC, WR_REC_CYC), umax(RD_CYC, TURN_CYC));
    localparam int unsigned TMR_W      = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ce1_n;
        logic              ce2;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              ready;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st: ST_IDLE, addr: '0, wdata: '0, rdata: '0,
        ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ready: 1'b0
    };

    seq_regs_t        r_d, r_q;
    logic             pwr_ok;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_last;

    sram_powerup_gate #(.HOLD_CYC(PWR_CYC)) u_gate (
        .clk (clk),
        .rst (rst),
        .ok  (pwr_ok)
    );

    sram_phase_timer #(.CW(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_req && pwr_ok) begin
                    r_d.addr  = host_addr;
                    r_d.wdata = host_wdata;
                    r_d.ce1_n = 1'b0;
                    r_d.ce2   = 1'b1;
                    tmr_load  = 1'b1;
                    if (host_wr) begin
                        r_d.st    = ST_WR_LOW;
                        r_d.we_n  = 1'b0;
                        r_d.oe_n  = 1'b1;
                        r_d.dq_oe = 1'b1;
                        tmr_val   = TMR_W'(WR_LOW_CYC);
                    end else begin
                        r_d.st    = ST_RD_OE;
                        r_d.oe_n  = 1'b0;
                        tmr_val   = TMR_W'(RD_CYC);
                    end
                end
            end
            ST_WR_LOW: begin
                if (tmr_last) begin
                    r_d.st    = ST_WR_REC;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(WR_REC_CYC);
                end
            end
            ST_WR_REC: begin
                if (tmr_last) begin
                    r_d.st    = ST_IDLE;
                    r_d.ce1_n = 1'b1;
                    r_d.ce2   = 1'b0;
                    r_d.ready = 1'b1;
                end
            end
            ST_RD_OE: begin
                if (tmr_last) begin
                    r_d.st    = ST_RD_TURN;
                    r_d.rdata = mem_dq_in;
                    r_d.ready = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.ce1_n = 1'b1;
                    r_d.ce2   = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(TURN_CYC);
                end
            end
            ST_RD_TURN: begin
                if (tmr_last) r_d.st = ST_IDLE;
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= REGS_RST;
        else     r_q <= r_d;
    end

    assign host_busy  = !pwr_ok || (r_q.st != ST_IDLE);
    assign host_ready = r_q.ready;
    assign host_rdata = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_ce1_n  = r_q.ce1_n;
    assign mem_ce2    = r_q.ce2;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        ce1_n,
    input logic        ce2,
    input logic        oe_n,
    input logic        we_n,
    input logic        dq_oe,
    input logic        ready,
    input logic        busy,
    input logic        pwr_ok,
    input logic [15:0] we_min
);
    logic [15:0] we_cnt_d, we_cnt_q;

    always_comb begin
        if (we_n)                  we_cnt_d = '0;
        else if (we_cnt_q != '1)   we_cnt_d = we_cnt_q + 1'b1;
        else                       we_cnt_d = we_cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) we_cnt_q <= '0;
        else     we_cnt_q <= we_cnt_d;
    end

    AST_HOLDOFF_DESELECT: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> (ce1_n && !ready)); // R2

    AST_DRIVE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!ce1_n && ce2 && !we_n && oe_n)); // R3

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_cnt_q >= we_min)); // R3

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready); // R6

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n); // R8

    AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> !$past(dq_oe)); // R8

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ce1_n && !ce2 && oe_n && we_n)); // R9
endmodule

bind sram_seq_ctrl sram_seq_chk u_seq_chk (
    .clk    (clk),
    .rst    (rst),
    .ce1_n  (mem_ce1_n),
    .ce2    (mem_ce2),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n),
    .dq_oe  (mem_dq_oe),
    .ready  (host_ready),
    .busy   (host_busy),
    .pwr_ok (pwr_ok),
    .we_min (16'(WR_LOW_CYC))
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
    localparam int CLK_PS = 5000;

    function automatic int cyc(int ps);
        int c;
        c = (ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int WL_E   = mx(mx(cyc(7000), cyc(7000)), cyc(6000));
    localparam int WC_E   = cyc(10000);
    localparam int REC_E  = (WC_E > WL_E) ? WC_E - WL_E : 1;
    localparam int RL_E   = mx(cyc(10000), cyc(5000));
    localparam int TURN_E = cyc(5000);
    localparam int PWR_E  = cyc(100_000_000);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_busy, host_ready;
    logic [7:0]  host_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;

    int checks = 0;
    int errors = 0;

    always #2500ps clk = ~clk;

    sram_seq_ctrl uut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_ready(host_ready), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // RAM contents as seen by the pin model, and as predicted from host traffic
    logic [7:0] ram [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] init_byte(int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] ram_get(int a);
        if (ram.exists(a)) return ram[a];
        return init_byte(a);
    endfunction
    function automatic logic [7:0] exp_get(int a);
        if (shadow.exists(a)) return shadow[a];
        return init_byte(a);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pin-level RAM model and protocol monitor, evaluated between edges
    bit          wr_act_p = 0;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    int          we_low = 0;
    int          sel_cnt = 0;
    bit          sel_wr = 0;
    int          oe_hi = 100;
    logic        dq_oe_p = 0;
    logic        oe_n_p = 1;

    always @(negedge clk) begin
        if (rst) begin
            wr_act_p = 0; we_low = 0; sel_cnt = 0; sel_wr = 0; oe_hi = 100;
            dq_oe_p = 0; oe_n_p = 1; mem_dq_in <= 8'hA5;
        end else begin
            bit act;
            act = !mem_ce1_n && mem_ce2 && !mem_we_n;
            if (mem_dq_oe && !mem_oe_n) check(0, "R8 bus driven with OE low", 1, 0);
            if (!mem_oe_n && oe_n_p && dq_oe_p) check(0, "R8 OE fell right after drive", 1, 0);
            if (mem_dq_oe && !dq_oe_p) check(oe_hi >= TURN_E, "R8 turnaround gap", oe_hi, TURN_E);
            if (act) begin
                if (!mem_dq_oe || !mem_oe_n) check(0, "R3 write strobes", {mem_dq_oe, mem_oe_n}, 3);
                if (we_low > 0 && (mem_addr != wr_addr || mem_dq_out != wr_data))
                    check(0, "R3 address/data stable", mem_dq_out, wr_data);
                wr_addr = mem_addr;
                wr_data = mem_dq_out;
                we_low++;
                sel_wr = 1;
            end else if (wr_act_p) begin
                ram[int'(wr_addr)] = wr_data;
                check(we_low == WL_E, "R3 WE low width", we_low, WL_E);
                check(!mem_dq_oe, "R3 bus released with WE", mem_dq_oe, 0);
                we_low = 0;
            end
            wr_act_p = act;
            if (!mem_ce1_n && mem_ce2) sel_cnt++;
            else begin
                if (sel_wr) check(sel_cnt >= WC_E, "R4 write cycle length", sel_cnt, WC_E);
                sel_cnt = 0; sel_wr = 0;
            end
            if (!host_busy && !(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n))
                check(0, "R9 idle not in standby", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
            if (mem_oe_n) oe_hi++; else oe_hi = 0;
            dq_oe_p = mem_dq_oe;
            oe_n_p  = mem_oe_n;
            mem_dq_in <= (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
                         ? ram_get(int'(mem_addr)) : 8'hA5;
        end
    end

    task automatic access(bit wr, logic [16:0] a, logic [7:0] d);
        int n;
        logic [7:0] got;
        while (host_busy) @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 0;
        n = 1;
        while (!host_ready && n < 50) begin @(negedge clk); n++; end
        got = host_rdata;
        if (wr) begin
            check(n == 1 + WL_E + REC_E, "R4 write latency", n, 1 + WL_E + REC_E);
            shadow[int'(a)] = d;
        end else begin
            check(n == 1 + RL_E, "R5 read latency", n, 1 + RL_E);
            check(got == exp_get(int'(a)), "R5 read data", got, exp_get(int'(a)));
        end
        @(negedge clk);
        check(!host_ready, "R6 ready single cycle", host_ready, 0);
        if (!wr) check(host_rdata == got, "R6 rdata held", host_rdata, got);
    endtask

    task automatic busy_ignore(bit wr_first, logic [16:0] a, logic [16:0] b);
        int readies;
        while (host_busy) @(negedge clk);
        host_req = 1; host_wr = wr_first; host_addr = a; host_wdata = 8'h3C;
        @(negedge clk);
        host_wr = 1; host_addr = b; host_wdata = 8'hC3;
        readies = host_ready ? 1 : 0;
        @(negedge clk);
        if (host_ready) readies++;
        host_req = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (host_ready) readies++;
        end
        check(readies == 1, "R7 one access while busy", readies, 1);
        if (wr_first) shadow[int'(a)] = 8'h3C;
        access(0, b, 8'h00);
        access(0, a, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int viol;
        logic [16:0] pool [8];
        void'($urandom(32'h51A7));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !host_ready,
              "R1 reset pins", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, host_ready}, 6'b101100);
        rst = 0;
        @(negedge clk);
        n = 1;
        check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !host_ready,
              "R1 first cycle", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, host_ready}, 6'b101100);
        // R2: hold-off window with a pending write request
        viol = 0;
        host_req = 1; host_wr = 1; host_addr = 17'h00055; host_wdata = 8'h77;
        while (host_busy && n < PWR_E + 10) begin
            if (n == PWR_E - 5) host_req = 0;
            if (!mem_ce1_n || host_ready) viol++;
            @(negedge clk);
            n++;
        end
        host_req = 0;
        check(n == PWR_E, "R2 hold-off length", n, PWR_E);
        check(viol == 0, "R2 no access during hold-off", viol, 0);
        access(0, 17'h00055, 8'h00);   // R2: location untouched
        // directed corners: boundaries and data extremes
        access(1, 17'h00000, 8'hFF);
        access(1, 17'h1FFFF, 8'h00);
        access(0, 17'h00000, 8'h00);
        access(0, 17'h1FFFF, 8'h00);
        access(1, 17'h10000, 8'hA5);
        access(0, 17'h10000, 8'h00);
        access(1, 17'h0AAAA, 8'h5A);   // write right after write
        access(0, 17'h0AAAA, 8'h00);
        access(1, 17'h0AAAA, 8'h81);   // write right after read: turnaround
        access(0, 17'h0AAAA, 8'h00);
        // R7: requests while busy are dropped
        busy_ignore(1, 17'h00123, 17'h00456);
        busy_ignore(0, 17'h00789, 17'h00ABC);
        // constrained random mix
        for (int i = 0; i < 8; i++) pool[i] = 17'($urandom);
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            a = ($urandom % 3 == 0) ? 17'($urandom) : pool[$urandom % 8];
            access(1'($urandom % 2), a, 8'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule